// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Receiver

This block receives one data word per frame from a serial line. A single-bit frame marker, active high, announces each frame. The receiver samples the marker, the data line and its delay setting on the falling edge of the serial bit clock. The first falling edge on which the marker is seen high while the receiver is idle is the frame start. The first data bit is then taken on that same edge, one edge later or two edges later, as a 2-bit delay setting selects. The receiver then shifts in the rest of the word, most significant bit first.

After the last bit arrives, the receiver loads the whole word onto a parallel output and raises a valid strobe for one bit-clock period. While a word is being received, the receiver ignores any further frame marker. A new frame may begin on the edge right after the last data bit.

The controller has three states:

- **ST_IDLE** waits for the marker.
- **ST_SKIP** uses up the one extra bit clock of a two-bit delay.
- **ST_SHIFT** collects the bits.

The transitions are:

- **start-now**: ST_IDLE to ST_SHIFT. Delay 0; the first bit is already captured.
- **start-next**: ST_IDLE to ST_SHIFT. Delay 1.
- **start-skip**: ST_IDLE to ST_SKIP. Delay 2.
- **skip-done**: ST_SKIP to ST_SHIFT.
- **word-end**: ST_SHIFT to ST_IDLE, when the last bit is captured.
- **reset**: any state to ST_IDLE.

The word length is the parameter `WORD_W`, with a default of 8.

Top module: `fs_serial_rx`

## Requirements
- R1: The frame start is the first falling edge of `bclk` on which `fsync` is sampled high while the receiver is idle. If `fsync` is still high on the following edges of that frame, those edges do not restart the frame.
- R2: With `lag_sel` = 2'b00, the first data bit is sampled on the frame-start edge itself.
- R3: With `lag_sel` = 2'b01, the first data bit is sampled on the falling edge after the frame-start edge.
- R4: With `lag_sel` = 2'b10, the first data bit is sampled on the second falling edge after the frame-start edge.
- R5: The setting `lag_sel` = 2'b11 behaves exactly like 2'b10.
- R6: Bits arrive most significant first. The first sampled data bit lands in `rx_word[WORD_W-1]` and the last one in `rx_word[0]`.
- R7: `rx_word` and `rx_valid` change only on falling edges of `bclk`. On the edge that captures the last bit, `rx_word` takes the new word and `rx_valid` goes high for exactly one bit-clock period. At all other times `rx_word` holds its value. Line values outside the data bits have no effect.
- R8: An `fsync` pulse while a word is in progress is ignored. A new frame may start on the edge right after the last data bit of the previous word.
- R9: `rst` is asynchronous and active high. While it is high, the receiver is idle, `rx_valid` is 0 and `rx_word` is 0. A word in progress when reset arrives is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all sampling on its falling edge |
| rst | input | 1 | Asynchronous reset, active high |
| fsync | input | 1 | Frame marker, active high |
| sdata | input | 1 | Serial data line |
| lag_sel | input | 2 | Delay from frame start to first bit: 00=0, 01=1, 10=2, 11=2 |
| rx_word | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | High for one bit-clock period when `rx_word` is updated |

## Verification
The hardest situation to reach from the ports is a frame marker that lands inside a word in progress. The case that matters most is a marker on the very edge that captures the last bit, or on the edge just after it, where the next frame legally starts. The stimulus sends frames with extra marker pulses scattered at random over the data slots, and markers held high for two cycles. It also runs frames back to back with no idle slots, under every delay setting including the reserved one. A receiver that restarted, or that missed the next frame, would produce a wrong word or a missing or extra strobe.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SKIP  = 2'd1,
        ST_SHIFT = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        LAG_NONE = 2'd0,
        LAG_ONE  = 2'd1,
        LAG_TWO  = 2'd2
    } lag_e;

    // The reserved code 2'b11 folds onto the two-clock delay.
    function automatic lag_e decode_lag(input logic [1:0] sel);
        lag_e res;
        unique case (sel)
            2'b00:   res = LAG_NONE;
            2'b01:   res = LAG_ONE;
            default: res = LAG_TWO;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/rxd_lag_decode.sv
module rxd_lag_decode
    import rxd_pkg::*;
(
    input  logic [1:0] lag_sel,
    output lag_e       lag
);

    always_comb begin
        lag = decode_lag(lag_sel);
    end

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
    import rxd_pkg::*;
#(
    parameter  int WORD_W = 8,
    localparam int CNT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic             bclk,
    input  logic             rst,
    input  logic             fsync,
    input  lag_e             lag,
    output rx_state_e        state,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             shift_en,
    output logic             word_done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam bit SINGLE_BIT = (WORD_W == 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register, sampled on the falling edge of the bit clock.
    always_ff @(negedge bclk or posedge rst) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fsync) begin
                    unique case (lag)
                        LAG_NONE: begin
                            // The first bit is taken on this edge.
                            if (!SINGLE_BIT) begin
                                state_d = ST_SHIFT;
                                cnt_d   = CNT_W'(1);
                            end
                        end
                        LAG_ONE: begin
                            state_d = ST_SHIFT;
                            cnt_d   = '0;
                        end
                        default: begin
                            state_d = ST_SKIP;
                            cnt_d   = '0;
                        end
                    endcase
                end
            end
            ST_SKIP: begin
                state_d = ST_SHIFT;
                cnt_d   = '0;
            end
            ST_SHIFT: begin
                // A frame marker here is ignored: only the count matters.
                if (cnt_q == LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs of the controller.
    always_comb begin
        shift_en  = 1'b0;
        word_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fsync && (lag == LAG_NONE)) begin
                    shift_en  = 1'b1;
                    word_done = SINGLE_BIT;
                end
            end
            ST_SHIFT: begin
                shift_en  = 1'b1;
                word_done = (cnt_q == LAST);
            end
            default: begin
                shift_en  = 1'b0;
                word_done = 1'b0;
            end
        endcase
    end

    assign state   = state_q;
    assign bit_cnt = cnt_q;

endmodule

// File: rtl/rxd_shreg.sv
module rxd_shreg #(
    parameter int WORD_W = 8
) (
    input  logic              bclk,
    input  logic              rst,
    input  logic              sdata,
    input  logic              shift_en,
    input  logic              word_done,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    logic [WORD_W-1:0] next_word;

    generate
        if (WORD_W == 1) begin : g_single
            // A one-bit word is the sampled bit itself.
            assign next_word = sdata;
        end else begin : g_multi
            logic [WORD_W-2:0] acc_q;

            always_ff @(negedge bclk or posedge rst) begin
                if (rst) begin
                    acc_q <= '0;
                end else if (shift_en) begin
                    acc_q <= next_word[WORD_W-2:0];
                end
            end

            // Earlier bits move toward the MSB; the new bit enters at bit 0.
            assign next_word = {acc_q, sdata};
        end
    endgenerate

    always_ff @(negedge bclk or posedge rst) begin
        if (rst) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= word_done;
            if (word_done) begin
                rx_word <= next_word;
            end
        end
    end

endmodule

// File: rtl/fs_serial_rx.sv
module fs_serial_rx
    import rxd_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              bclk,
    input  logic              rst,
    input  logic              fsync,
    input  logic              sdata,
    input  logic [1:0]        lag_sel,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    lag_e             lag_w;
    rx_state_e        state_w;
    logic [CNT_W-1:0] cnt_w;
    logic             shift_w;
    logic             done_w;

    rxd_lag_decode u_decode (
        .lag_sel (lag_sel),
        .lag     (lag_w)
    );

    rxd_ctrl #(
        .WORD_W (WORD_W)
    ) u_ctrl (
        .bclk      (bclk),
        .rst       (rst),
        .fsync     (fsync),
        .lag       (lag_w),
        .state     (state_w),
        .bit_cnt   (cnt_w),
        .shift_en  (shift_w),
        .word_done (done_w)
    );

    rxd_shreg #(
        .WORD_W (WORD_W)
    ) u_shreg (
        .bclk      (bclk),
        .rst       (rst),
        .sdata     (sdata),
        .shift_en  (shift_w),
        .word_done (done_w),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

endmodule

// File: rtl/rxd_checker.sv
module rxd_checker
    import rxd_pkg::*;
#(
    parameter  int WORD_W = 8,
    localparam int CNT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input logic              bclk,
    input logic              rst,
    input logic              fsync,
    input logic [1:0]        lag_sel,
    input lag_e              lag,
    input rx_state_e         state,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              word_done,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_valid
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    always @(negedge bclk) begin
        if (rst) begin
            assert_idle_in_reset_R9: assert (!rx_valid && state == ST_IDLE && rx_word == '0)
                else $error("receiver active during reset");
        end else begin
            assert_reserved_lag_R5: assert (lag_sel != 2'b11 || lag == LAG_TWO)
                else $error("reserved delay code not folded onto two");
        end
    end

    assert_word_holds_R7: assert property (@(negedge bclk) disable iff (rst)
        !rx_valid |-> $stable(rx_word));

    assert_done_strobe_R7: assert property (@(negedge bclk) disable iff (rst)
        word_done |=> rx_valid);

    generate
        if (WORD_W > 1) begin : g_multi
            assert_single_strobe_R7: assert property (@(negedge bclk) disable iff (rst)
                rx_valid |=> !rx_valid);

            assert_lag_zero_R2: assert property (@(negedge bclk) disable iff (rst)
                (state == ST_IDLE && fsync && lag == LAG_NONE)
                |=> (state == ST_SHIFT && bit_cnt == CNT_W'(1)));
        end
    endgenerate

    assert_lag_one_R3: assert property (@(negedge bclk) disable iff (rst)
        (state == ST_IDLE && fsync && lag == LAG_ONE)
        |=> (state == ST_SHIFT && bit_cnt == '0));

    assert_lag_two_R4: assert property (@(negedge bclk) disable iff (rst)
        (state == ST_IDLE && fsync && lag == LAG_TWO) |=> (state == ST_SKIP));

    assert_skip_to_shift_R4: assert property (@(negedge bclk) disable iff (rst)
        (state == ST_SKIP) |=> (state == ST_SHIFT && bit_cnt == '0));

    assert_busy_ignores_sync_R8: assert property (@(negedge bclk) disable iff (rst)
        (state == ST_SHIFT && bit_cnt != LAST) |=> (state == ST_SHIFT && !rx_valid));

    assert_idle_stays_R1: assert property (@(negedge bclk) disable iff (rst)
        (state == ST_IDLE && !fsync) |=> (state == ST_IDLE));

endmodule

bind fs_serial_rx rxd_checker #(
    .WORD_W (WORD_W)
) u_rxd_checker (
    .bclk      (bclk),
    .rst       (rst),
    .fsync     (fsync),
    .lag_sel   (lag_sel),
    .lag       (lag_w),
    .state     (state_w),
    .bit_cnt   (cnt_w),
    .word_done (done_w),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid)
);

// File: tb/fs_serial_rx_bench.sv
`timescale 1ns/1ps
module fs_serial_rx_bench;

    localparam int W = 8;

    logic         bclk = 1'b0;
    logic         rst = 1'b1;
    logic         fsync = 1'b0;
    logic         sdata = 1'b0;
    logic [1:0]   lag_sel = 2'b01;
    logic [W-1:0] rx_word;
    logic         rx_valid;

    int n_checks = 0;
    int n_fails  = 0;

    logic         pend_v   = 1'b0;
    logic [W-1:0] pend_w   = '0;
    string        pend_tag = "R9";

    always #2 bclk = ~bclk;

    fs_serial_rx #(.WORD_W(W)) u_fs_serial_rx (
        .bclk     (bclk),
        .rst      (rst),
        .fsync    (fsync),
        .sdata    (sdata),
        .lag_sel  (lag_sel),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    function automatic int eff_lag(input logic [1:0] sel);
        return (sel == 2'b11) ? 2 : int'(sel);
    endfunction

    function automatic string lag_tag(input logic [1:0] sel);
        case (sel)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Outputs are read at the rising edge, half a period after the
    // falling edge that updates them.
    task automatic check_out();
        n_checks++;
        if (rx_valid !== pend_v) begin
            n_fails++;
            $display("FAIL %s/R7 rx_valid actual=%b expected=%b at %0t",
                     pend_tag, rx_valid, pend_v, $time);
        end
        if (pend_v) begin
            n_checks++;
            if (rx_word !== pend_w) begin
                n_fails++;
                $display("FAIL %s/R6 rx_word actual=%h expected=%h at %0t",
                         pend_tag, rx_word, pend_w, $time);
            end
        end
    endtask

    task automatic tick(input logic fs, input logic d, input logic fin,
                        input logic [W-1:0] w, input string tag);
        @(posedge bclk);
        check_out();
        fsync   <= fs;
        sdata   <= d;
        pend_v   = fin;
        pend_w   = w;
        pend_tag = tag;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            tick(1'b0, 1'($urandom), 1'b0, '0, "R8");
        end
    endtask

    task automatic frame(input logic [1:0] sel, input logic [W-1:0] w,
                         input int fs_len, input bit noise, input string tag);
        int lg;
        int n;
        lg = eff_lag(sel);
        n  = lg + W;
        lag_sel <= sel;
        for (int j = 0; j < n; j++) begin
            logic fs;
            logic d;
            fs = (j < fs_len) || (noise && j > 0 && ($urandom % 3 == 0));
            d  = (j >= lg) ? w[W-1-(j-lg)] : 1'($urandom);
            tick(fs, d, (j == n - 1), w, tag);
        end
    endtask

    task automatic do_reset(input int k);
        @(posedge bclk);
        check_out();
        rst   <= 1'b1;
        fsync <= 1'b0;
        pend_v   = 1'b0;
        pend_tag = "R9";
        for (int i = 0; i < k; i++) begin
            @(posedge bclk);
            check_out();
            n_checks++;
            if (rx_word !== '0) begin
                n_fails++;
                $display("FAIL R9 rx_word in reset actual=%h expected=%h", rx_word, {W{1'b0}});
            end
        end
        rst <= 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog expired, all requirements affected");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R9: state held in reset from time zero
        do_reset(3);
        idle(3);

        // R2, R3, R4, R5: each delay code with a distinct pattern
        frame(2'b00, 8'hA5, 1, 1'b0, "R2");
        idle(2);
        frame(2'b01, 8'h3C, 1, 1'b0, "R3");
        idle(2);
        frame(2'b10, 8'h81, 1, 1'b0, "R4");
        idle(2);
        frame(2'b11, 8'h7E, 1, 1'b0, "R5");
        idle(2);

        // R6: single set bit at each end
        frame(2'b01, 8'h80, 1, 1'b0, "R6");
        frame(2'b01, 8'h01, 1, 1'b0, "R6");
        idle(1);

        // R1: marker held for two cycles does not restart the frame
        frame(2'b01, 8'hC3, 2, 1'b0, "R1");
        frame(2'b00, 8'h5A, 2, 1'b0, "R1");
        idle(1);

        // R8: markers inside the word, then back-to-back frames
        frame(2'b01, 8'h96, 1, 1'b1, "R8");
        frame(2'b00, 8'hF0, 1, 1'b1, "R8");
        frame(2'b10, 8'h0F, 1, 1'b1, "R8");
        idle(4);

        // R9: reset in the middle of a word discards it
        lag_sel <= 2'b01;
        tick(1'b1, 1'b1, 1'b0, '0, "R9");
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b0, '0, "R9");
        do_reset(2);
        idle(W + 3);
        frame(2'b01, 8'h42, 1, 1'b0, "R9");
        idle(2);

        // Random frames under every delay code
        for (int f = 0; f < 150; f++) begin
            logic [1:0] sel;
            sel = 2'($urandom);
            frame(sel, W'($urandom), 1 + int'($urandom % 2), bit'($urandom % 2), lag_tag(sel));
            idle(int'($urandom % 3));
        end
        idle(3);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule